// File: doc/BRIEF.md
# Stand-by Clock Mode Controller

This block decides what a two-output clock generator drives while it is on stand-by. In normal running it passes a video clock and a memory clock straight through to its outputs. When an active-low request pin is pulled low, it enters one of two low-power states. A control bit, which must already be set when the pin falls, selects the state.

In the light state, the oscillator enable is removed and the video output is parked high. The memory output then toggles from the reference clock at a programmable even ratio, so that dynamic memory keeps being refreshed. In the deep state, both clock outputs and the oscillator enable are forced low, and the reference-run enable is removed as well.

The 4-bit ratio register keeps its value through either state. Releasing the pin returns the block to normal running. The pin is resynchronised to the reference clock, and every output selection changes only on a reference edge.

Top module: `pdClockCtrl`

## Requirements
- R1: In normal mode vidClkOut equals vidClkIn, memClkOut equals memClkIn, and oscEn and refRunEn are both 1. This is also the state directly after reset.
- R2: When the request is low and deepSel is 0 at entry, the block is in the light mode: oscEn is 0, refRunEn is 1 and vidClkOut is 1.
- R3: In the light mode memClkOut has a period of (34 - 2*code) reference cycles, where code is the 4-bit ratio register value 1..15 (1 gives 32, 15 gives 4). The high and low phases each last half of that period.
- R4: Code 0 behaves as code 8, giving a ratio of 18.
- R5: After reset the ratio register holds code 8, so the light-mode period is 18 cycles.
- R6: When the request is low and deepSel is 1 at entry, the block is in the deep mode: vidClkOut, memClkOut, oscEn and refRunEn are all 0.
- R7: The mode is fixed at entry. A change of deepSel while the request stays low does not move the block between the light and deep modes.
- R8: When the request returns high, the block returns to the R1 behaviour, and the ratio register still holds its value from before.
- R9: A change on pdReqN, sampled at a rising reference edge, takes effect on the outputs right after the third rising edge counted from that one. This comes from two synchroniser stages and the mode register.
- R10: A ratio register write made during the light mode does not alter the half-phase in progress. The new ratio applies from the next phase boundary.
- R11: On entry to the light mode memClkOut starts low and first rises ratio/2 reference edges after the mode register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; clocks all state |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReqN | input | 1 | Asynchronous active-low stand-by request |
| deepSel | input | 1 | Control bit: 1 selects the deep mode at entry |
| divWe | input | 1 | Write strobe for the ratio register |
| divWdata | input | 4 | Ratio code to write |
| vidClkIn | input | 1 | Video clock from the synthesiser |
| memClkIn | input | 1 | Memory clock from the synthesiser |
| vidClkOut | output | 1 | Selected video clock |
| memClkOut | output | 1 | Selected memory clock |
| oscEn | output | 1 | Enable for the synthesiser oscillators |
| refRunEn | output | 1 | Enable for the reference oscillator path |

## Verification
The hardest case to reach from the ports is a ratio write that lands in the middle of a refresh half-phase. The port shows only the output level, not the internal count. The bench therefore waits for a rising edge on memClkOut, writes a much shorter ratio on the next edge, and then measures the high phase in progress and the phases after it. A second case that needs deliberate stimulus is flipping deepSel while a stand-by mode is held. That flip has to be made after the request has passed the synchroniser, so the bench waits out the three-edge entry latency before changing the bit.

// File: rtl/pdClkPkg.sv
package pdClkPkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2
  } pdMode_t;

  typedef struct packed {
    logic enterLight;
    logic enterDeep;
    logic leavePd;
  } pdStrobe_t;
endpackage

// File: rtl/pdCtrl.sv
module pdCtrl
  import pdClkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      refClk,
  input  logic      rstN,
  input  logic      pdReqN,
  input  logic      deepSel,
  output pdMode_t   mode,
  output pdStrobe_t strobe
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic reqActive;

  // Request pin resynchronised into the reference domain
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pdReqN};
  end

  assign reqActive = ~syncQ[SYNC_STAGES-1];

  // Mode choice is made only when leaving normal running
  always_comb begin
    strobe = '0;
    case (mode)
      MODE_NORM: begin
        if (reqActive) begin
          if (deepSel) strobe.enterDeep  = 1'b1;
          else         strobe.enterLight = 1'b1;
        end
      end
      default: begin
        if (!reqActive) strobe.leavePd = 1'b1;
      end
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 mode <= MODE_NORM;
    else if (strobe.enterLight) mode <= MODE_LIGHT;
    else if (strobe.enterDeep)  mode <= MODE_DEEP;
    else if (strobe.leavePd)    mode <= MODE_NORM;
  end
endmodule

// File: rtl/pdDatapath.sv
module pdDatapath
  import pdClkPkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int RST_CODE = 8
) (
  input  logic              refClk,
  input  logic              rstN,
  input  pdMode_t           mode,
  input  pdStrobe_t         strobe,
  input  logic              divWe,
  input  logic [CODE_W-1:0] divWdata,
  input  logic              vidClkIn,
  input  logic              memClkIn,
  output logic              vidClkOut,
  output logic              memClkOut,
  output logic              oscEn,
  output logic              refRunEn
);
  localparam int HALF_TOP = (1 << CODE_W) + 1;
  localparam int CNT_W    = $clog2(HALF_TOP + 1);

  logic [CODE_W-1:0] divReg;
  logic [CNT_W-1:0]  halfSel;
  logic [CNT_W-1:0]  cnt;
  logic              divOut;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)      divReg <= CODE_W'(RST_CODE);
    else if (divWe) divReg <= divWdata;
  end

  // Half period in reference cycles; code 0 falls back to the reset code
  always_comb begin
    if (divReg == '0) halfSel = CNT_W'(HALF_TOP - RST_CODE);
    else              halfSel = CNT_W'(HALF_TOP) - CNT_W'(divReg);
  end

  // Ratio is sampled only at a phase boundary
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else if (strobe.enterLight) begin
      cnt    <= halfSel - CNT_W'(1);
      divOut <= 1'b0;
    end else if (mode == MODE_LIGHT) begin
      if (cnt == '0) begin
        divOut <= ~divOut;
        cnt    <= halfSel - CNT_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end else begin
      divOut <= 1'b0;
    end
  end

  always_comb begin
    case (mode)
      MODE_LIGHT: begin
        vidClkOut = 1'b1;
        memClkOut = divOut;
        oscEn     = 1'b0;
        refRunEn  = 1'b1;
      end
      MODE_DEEP: begin
        vidClkOut = 1'b0;
        memClkOut = 1'b0;
        oscEn     = 1'b0;
        refRunEn  = 1'b0;
      end
      default: begin
        vidClkOut = vidClkIn;
        memClkOut = memClkIn;
        oscEn     = 1'b1;
        refRunEn  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pdClockCtrl.sv
module pdClockCtrl
  import pdClkPkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int RST_CODE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              pdReqN,
  input  logic              deepSel,
  input  logic              divWe,
  input  logic [CODE_W-1:0] divWdata,
  input  logic              vidClkIn,
  input  logic              memClkIn,
  output logic              vidClkOut,
  output logic              memClkOut,
  output logic              oscEn,
  output logic              refRunEn
);
  pdMode_t   mode;
  pdStrobe_t strobe;

  pdCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .refClk (refClk),
    .rstN   (rstN),
    .pdReqN (pdReqN),
    .deepSel(deepSel),
    .mode   (mode),
    .strobe (strobe)
  );

  pdDatapath #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) i_dp (
    .refClk   (refClk),
    .rstN     (rstN),
    .mode     (mode),
    .strobe   (strobe),
    .divWe    (divWe),
    .divWdata (divWdata),
    .vidClkIn (vidClkIn),
    .memClkIn (memClkIn),
    .vidClkOut(vidClkOut),
    .memClkOut(memClkOut),
    .oscEn    (oscEn),
    .refRunEn (refRunEn)
  );
endmodule

// File: rtl/pdClockCtrlChk.sv
module pdClockCtrlChk (
  input logic refClk,
  input logic rstN,
  input logic vidClkIn,
  input logic memClkIn,
  input logic vidClkOut,
  input logic memClkOut,
  input logic oscEn,
  input logic refRunEn
);
  logic lightNow;
  assign lightNow = !oscEn && refRunEn;

  AST_NORMAL_PASS: assert property (@(posedge refClk) disable iff (!rstN)
    oscEn |-> (vidClkOut == vidClkIn && memClkOut == memClkIn)); // R1

  AST_LIGHT_VID_HIGH: assert property (@(posedge refClk) disable iff (!rstN)
    lightNow |-> vidClkOut); // R2

  AST_DEEP_QUIET: assert property (@(posedge refClk) disable iff (!rstN)
    !refRunEn |-> (!vidClkOut && !memClkOut && !oscEn)); // R6

  AST_NO_LIGHT_TO_DEEP: assert property (@(posedge refClk) disable iff (!rstN)
    lightNow |=> refRunEn); // R7

  AST_MIN_HALF_PHASE: assert property (@(posedge refClk) disable iff (!rstN)
    (lightNow && $past(lightNow) && memClkOut != $past(memClkOut))
      |=> (!lightNow || $stable(memClkOut))); // R3
endmodule

bind pdClockCtrl pdClockCtrlChk i_pdClockCtrlChk (
  .refClk   (refClk),
  .rstN     (rstN),
  .vidClkIn (vidClkIn),
  .memClkIn (memClkIn),
  .vidClkOut(vidClkOut),
  .memClkOut(memClkOut),
  .oscEn    (oscEn),
  .refRunEn (refRunEn)
);

// File: tb/test_pdClockCtrl.sv
`timescale 1ns/1ps
module test_pdClockCtrl;
  logic clk = 1'b0;
  logic rstN, pdReqN, deepSel, divWe, vidClkIn, memClkIn;
  logic [3:0] divWdata;
  logic vidClkOut, memClkOut, oscEn, refRunEn;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pdClockCtrl i_pdClockCtrl (
    .refClk(clk), .rstN(rstN), .pdReqN(pdReqN), .deepSel(deepSel),
    .divWe(divWe), .divWdata(divWdata), .vidClkIn(vidClkIn),
    .memClkIn(memClkIn), .vidClkOut(vidClkOut), .memClkOut(memClkOut),
    .oscEn(oscEn), .refRunEn(refRunEn)
  );

  typedef struct packed {
    logic [3:0] code;
    logic [7:0] ratio;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{4'd1, 8'd32}, '{4'd15, 8'd4}, '{4'd2, 8'd30}, '{4'd8, 8'd18},
    '{4'd10, 8'd14}, '{4'd0, 8'd18}, '{4'd14, 8'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCode(input logic [3:0] c);
    divWe = 1'b1; divWdata = c;
    tick(1);
    divWe = 1'b0;
  endtask

  task automatic enterPd(input logic deep);
    deepSel = deep; pdReqN = 1'b0;
    tick(3);
  endtask

  task automatic leavePd();
    pdReqN = 1'b1;
    tick(3);
  endtask

  task automatic waitRise();
    int guard = 0;
    while (memClkOut !== 1'b0 && guard < 100) begin tick(1); guard++; end
    while (memClkOut !== 1'b1 && guard < 200) begin tick(1); guard++; end
  endtask

  task automatic countPhase(input logic level, output int n);
    n = 0;
    while (memClkOut === level && n < 100) begin n++; tick(1); end
  endtask

  task automatic measure(input string req, input int ratio);
    int hi, lo;
    waitRise();
    countPhase(1'b1, hi);
    countPhase(1'b0, lo);
    chk(req, hi, ratio / 2);
    chk(req, lo, ratio / 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 1'b0; pdReqN = 1'b1; deepSel = 1'b0; divWe = 1'b0; divWdata = '0;
    vidClkIn = 1'b0; memClkIn = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1: reset state and pass-through under several input patterns
    chk("R1 oscEn", oscEn, 1);
    chk("R1 refRunEn", refRunEn, 1);
    for (int p = 0; p < 4; p++) begin
      vidClkIn = p[0]; memClkIn = p[1];
      #1;
      chk("R1 vid", vidClkOut, p[0]);
      chk("R1 mem", memClkOut, p[1]);
    end
    vidClkIn = 1'b1; memClkIn = 1'b1;

    // R5, R9, R2, R11: default ratio with entry latency
    pdReqN = 1'b0; deepSel = 1'b0;
    tick(2);
    chk("R9 not yet", oscEn, 1);
    tick(1);
    chk("R9 entered", oscEn, 0);
    chk("R2 vid high", vidClkOut, 1);
    chk("R2 refRunEn", refRunEn, 1);
    chk("R11 start low", memClkOut, 0);
    tick(8);
    chk("R11 low before rise", memClkOut, 0);
    tick(1);
    chk("R11 first rise", memClkOut, 1);
    measure("R5", 18);
    // R7: deepSel flips during the light mode
    deepSel = 1'b1;
    tick(5);
    chk("R7 stays light", refRunEn, 1);
    chk("R7 stays light osc", oscEn, 0);
    pdReqN = 1'b1;
    tick(2);
    chk("R9 exit not yet", oscEn, 0);
    tick(1);
    chk("R9 exited", oscEn, 1);
    deepSel = 1'b0;

    // R3, R4, R11: table of codes
    foreach (VECS[i]) begin
      writeCode(VECS[i].code);
      enterPd(1'b0);
      tick(VECS[i].ratio / 2 - 1);
      chk("R11 low before rise", memClkOut, 0);
      tick(1);
      chk("R11 first rise", memClkOut, 1);
      if (VECS[i].code == 4'd0) measure("R4", VECS[i].ratio);
      else                      measure("R3", VECS[i].ratio);
      leavePd();
    end

    // R6, R7, R8: deep mode, bit flip while held, retention
    writeCode(4'd12);
    vidClkIn = 1'b1; memClkIn = 1'b1;
    enterPd(1'b1);
    chk("R6 vid", vidClkOut, 0);
    chk("R6 mem", memClkOut, 0);
    chk("R6 osc", oscEn, 0);
    chk("R6 ref", refRunEn, 0);
    deepSel = 1'b0;
    tick(6);
    chk("R7 stays deep", refRunEn, 0);
    leavePd();
    chk("R8 osc", oscEn, 1);
    chk("R8 ref", refRunEn, 1);
    chk("R8 vid", vidClkOut, 1);
    enterPd(1'b0);
    measure("R8 retained", 10);
    leavePd();

    // R10: write in the middle of a high phase
    writeCode(4'd1);
    enterPd(1'b0);
    waitRise();
    divWe = 1'b1; divWdata = 4'd13;
    tick(1);
    divWe = 1'b0;
    countPhase(1'b1, n);
    chk("R10 current phase kept", n + 1, 16);
    countPhase(1'b0, n);
    chk("R10 new low phase", n, 4);
    countPhase(1'b1, n);
    chk("R10 new high phase", n, 4);
    leavePd();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule